// File: doc/BRIEF.md
# Clock Ratio Change Controller

This block holds the divider ratio selects for three internal clock domains: bus, CPU and peripheral. Software updates them through a one-cycle register write port. A change to the CPU or peripheral ratio reaches its select output on the next cycle. A change to the bus ratio also reaches its output on the next cycle when the second PLL is off.

When the second PLL is on, a bus ratio write is handled differently. The block gates off the enables of all three clock domains and loads an 8-bit up-counter from the `stab_start` input. The counter then advances once per cycle. When it wraps from 0xFF to 0x00, the clocks come back and the new bus ratio is applied in that same cycle. Software must set `stab_start` before it writes the bus ratio. The value on that input is sampled only at the write that starts the wait.

Top module: `clk_ratio_ctrl`

## Requirements
- R1: `wr_sel` selects the target field: 0 bus, 1 CPU, 2 peripheral. Each field is 3 bits and is taken from `wr_data[2:0]`, and the upper data bits are ignored. Code 3 is reserved, and a write with it changes nothing. After reset all three ratios are 0, all enables are 1 and `clocks_stopped` is 0.
- R2: An accepted CPU or peripheral write shows on `cpu_div` or `per_div` in the next cycle and never stops the clocks.
- R3: An accepted bus write with `pll_on` low shows on `bus_div` in the next cycle and never stops the clocks.
- R4: An accepted bus write with `pll_on` high raises `clocks_stopped` in the next cycle. It drives all three enables low and loads the counter from `stab_start`.
- R5: The counter steps by one each stopped cycle, and the wait ends on the wrap from 0xFF to 0x00. The clocks therefore stay stopped for exactly 256 − `stab_start` cycles, and a start value of 0 gives 256 cycles.
- R6: `bus_div` keeps its old value during the wait and takes the new ratio in the first cycle with the clocks running again.
- R7: Any write, to any field, that arrives while `clocks_stopped` is high is ignored.
- R8: `clocks_stopped` is high exactly when all three enables are low. A reset during a wait ends the wait and restores the reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_sel | input | 2 | Target field (0 bus, 1 CPU, 2 peripheral, 3 reserved) |
| wr_data | input | 8 | Write data, ratio in bits 2:0 |
| pll_on | input | 1 | Second PLL is running |
| stab_start | input | 8 | Stabilization counter start value |
| bus_div | output | 3 | Bus divider select |
| cpu_div | output | 3 | CPU divider select |
| per_div | output | 3 | Peripheral divider select |
| clk_en_bus | output | 1 | Bus clock enable |
| clk_en_cpu | output | 1 | CPU clock enable |
| clk_en_per | output | 1 | Peripheral clock enable |
| clocks_stopped | output | 1 | Internal clocks held off for stabilization |

## Verification
The bench measures the exact wait length at the two extremes. A start value of 0xFF gives 1 cycle, and a start value of 0 gives 256 cycles. A design that ended on the wrong count value, or treated 0 as "no wait", would be off by one or resume at once.

The bench checks that `bus_div` holds its old value during a wait. A design that applied the ratio at the write would switch dividers while the PLL is still unstable.

It writes the CPU and bus fields during a wait. A design that accepted those writes would retune dividers with the clocks stopped, or restart the wait.

Reserved-select writes and a reset in the middle of a wait are also covered. A design that got the reset case wrong would leave the clocks gated.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;

    typedef enum logic [1:0] {
        SEL_BUS = 2'd0,
        SEL_CPU = 2'd1,
        SEL_PER = 2'd2,
        SEL_RSV = 2'd3
    } ratio_sel_e;

endpackage

// File: rtl/stab_counter.sv
module stab_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] start_val,
    output logic             busy,
    output logic             done
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == CNT_MAX) begin
                st_d.busy = 1'b0;
            end
        end else if (load) begin
            st_d.busy = 1'b1;
            st_d.cnt  = start_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
    assign done = st_q.busy && (st_q.cnt == CNT_MAX);

    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !done) |=> (st_q.busy && st_q.cnt == CNT_W'($past(st_q.cnt) + 1'b1)));

    // R5
    wrap_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !st_q.busy);

    // R4
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !st_q.busy) |=> (st_q.busy && st_q.cnt == $past(start_val)));

endmodule

// File: rtl/ratio_bank.sv
module ratio_bank #(
    parameter int RATIO_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_cpu,
    input  logic               wr_per,
    input  logic               wr_bus_now,
    input  logic               wr_bus_defer,
    input  logic               apply_bus,
    input  logic [RATIO_W-1:0] ratio_in,
    output logic [RATIO_W-1:0] bus_div,
    output logic [RATIO_W-1:0] cpu_div,
    output logic [RATIO_W-1:0] per_div
);
    typedef struct packed {
        logic [RATIO_W-1:0] bus;
        logic [RATIO_W-1:0] cpu;
        logic [RATIO_W-1:0] per;
        logic [RATIO_W-1:0] pend;
    } bank_state_t;

    bank_state_t bk_d, bk_q;

    always_comb begin
        bk_d = bk_q;
        if (wr_cpu)       bk_d.cpu  = ratio_in;
        if (wr_per)       bk_d.per  = ratio_in;
        if (wr_bus_now)   bk_d.bus  = ratio_in;
        if (wr_bus_defer) bk_d.pend = ratio_in;
        if (apply_bus)    bk_d.bus  = bk_q.pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bk_q <= '0;
        end else begin
            bk_q <= bk_d;
        end
    end

    assign bus_div = bk_q.bus;
    assign cpu_div = bk_q.cpu;
    assign per_div = bk_q.per;

    // R6
    pend_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        apply_bus |=> (bus_div == $past(bk_q.pend)));

endmodule

// File: rtl/clk_ratio_ctrl.sv
module clk_ratio_ctrl
    import clk_ratio_pkg::*;
#(
    parameter int RATIO_W = 3,
    parameter int DATA_W  = 8,
    parameter int CNT_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               pll_on,
    input  logic [CNT_W-1:0]   stab_start,
    output logic [RATIO_W-1:0] bus_div,
    output logic [RATIO_W-1:0] cpu_div,
    output logic [RATIO_W-1:0] per_div,
    output logic               clk_en_bus,
    output logic               clk_en_cpu,
    output logic               clk_en_per,
    output logic               clocks_stopped
);
    logic               accept;
    logic               wr_bus, wr_cpu, wr_per;
    logic               bus_now, bus_defer;
    logic               cnt_busy, cnt_done;
    logic [RATIO_W-1:0] ratio_in;

    always_comb begin
        accept    = wr_en && !cnt_busy;
        wr_bus    = accept && (ratio_sel_e'(wr_sel) == SEL_BUS);
        wr_cpu    = accept && (ratio_sel_e'(wr_sel) == SEL_CPU);
        wr_per    = accept && (ratio_sel_e'(wr_sel) == SEL_PER);
        bus_now   = wr_bus && !pll_on;
        bus_defer = wr_bus && pll_on;
        ratio_in  = wr_data[RATIO_W-1:0];
    end

    stab_counter #(.CNT_W(CNT_W)) i_stab_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (bus_defer),
        .start_val (stab_start),
        .busy      (cnt_busy),
        .done      (cnt_done)
    );

    ratio_bank #(.RATIO_W(RATIO_W)) i_ratio_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_cpu       (wr_cpu),
        .wr_per       (wr_per),
        .wr_bus_now   (bus_now),
        .wr_bus_defer (bus_defer),
        .apply_bus    (cnt_done),
        .ratio_in     (ratio_in),
        .bus_div      (bus_div),
        .cpu_div      (cpu_div),
        .per_div      (per_div)
    );

    assign clk_en_bus     = !cnt_busy;
    assign clk_en_cpu     = !cnt_busy;
    assign clk_en_per     = !cnt_busy;
    assign clocks_stopped = cnt_busy;

    // R2
    cpu_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1 && !clocks_stopped) |=>
        (cpu_div == $past(wr_data[RATIO_W-1:0]) && !clocks_stopped));

    // R3
    bus_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0 && !pll_on && !clocks_stopped) |=>
        (bus_div == $past(wr_data[RATIO_W-1:0]) && !clocks_stopped));

    // R4
    stop_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0 && pll_on && !clocks_stopped) |=>
        (clocks_stopped && !clk_en_bus && !clk_en_cpu && !clk_en_per));

    // R6
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clocks_stopped |=> (!clocks_stopped || $stable(bus_div)));

    // R7
    cpu_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clocks_stopped |=> ($stable(cpu_div) && $stable(per_div)));

endmodule

// File: tb/test_clk_ratio_ctrl.sv
module test_clk_ratio_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic       pll_on = 1'b0;
    logic [7:0] stab_start = '0;
    logic [2:0] bus_div, cpu_div, per_div;
    logic       clk_en_bus, clk_en_cpu, clk_en_per, clocks_stopped;

    int n_run  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clk_ratio_ctrl i_clk_ratio_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .pll_on(pll_on), .stab_start(stab_start),
        .bus_div(bus_div), .cpu_div(cpu_div), .per_div(per_div),
        .clk_en_bus(clk_en_bus), .clk_en_cpu(clk_en_cpu),
        .clk_en_per(clk_en_per), .clocks_stopped(clocks_stopped)
    );

    typedef struct packed {
        logic [1:0] sel;
        logic [2:0] data;
        logic       pll;
        logic [7:0] start;
        logic [2:0] e_bus;
        logic [2:0] e_cpu;
        logic [2:0] e_per;
        logic [8:0] e_stop;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 3'd5, 1'b1, 8'h00, 3'd0, 3'd5, 3'd0, 9'd0},
        '{2'd2, 3'd3, 1'b1, 8'h00, 3'd0, 3'd5, 3'd3, 9'd0},
        '{2'd0, 3'd6, 1'b0, 8'h00, 3'd6, 3'd5, 3'd3, 9'd0},
        '{2'd0, 3'd2, 1'b1, 8'hFC, 3'd2, 3'd5, 3'd3, 9'd4},
        '{2'd1, 3'd7, 1'b0, 8'h00, 3'd2, 3'd7, 3'd3, 9'd0},
        '{2'd0, 3'd1, 1'b1, 8'hF0, 3'd1, 3'd7, 3'd3, 9'd16},
        '{2'd2, 3'd0, 1'b1, 8'h00, 3'd1, 3'd7, 3'd0, 9'd0},
        '{2'd0, 3'd4, 1'b1, 8'hFF, 3'd4, 3'd7, 3'd0, 9'd1}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] s, input logic [2:0] d,
                            input logic p, input logic [7:0] st);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = {5'b10101, d};
        pll_on = p; stab_start = st;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_run(inout int n);
        while (clocks_stopped && n < 400) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic check_ratios(input string req, input int b, input int c, input int p);
        check(bus_div == 3'(b), req, bus_div, b);
        check(cpu_div == 3'(c), req, cpu_div, c);
        check(per_div == 3'(p), req, per_div, p);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!ended) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int stops;
        int prev_bus;
        repeat (3) @(negedge clk);
        // R1 reset state
        check_ratios("R1 reset", 0, 0, 0);
        check(clk_en_bus && clk_en_cpu && clk_en_per, "R1 reset enables", 0, 1);
        check(!clocks_stopped, "R1 reset stopped", clocks_stopped, 0);
        rst_n = 1'b1;

        prev_bus = 0;
        for (int i = 0; i < NV; i++) begin
            do_write(VECS[i].sel, VECS[i].data, VECS[i].pll, VECS[i].start);
            stops = 0;
            if (VECS[i].e_stop != 0) begin
                // R4 enables low, R6 old bus ratio held
                check(clocks_stopped && !clk_en_bus && !clk_en_cpu && !clk_en_per,
                      "R4 stop entry", clocks_stopped, 1);
                check(bus_div == 3'(prev_bus), "R6 hold during wait", bus_div, prev_bus);
            end
            wait_run(stops);
            // R2 R3 R5 R6
            check(stops == int'(VECS[i].e_stop), "R5 wait length", stops, VECS[i].e_stop);
            check_ratios("R2/R3/R6 ratios", VECS[i].e_bus, VECS[i].e_cpu, VECS[i].e_per);
            check(clk_en_bus && clk_en_cpu && clk_en_per, "R8 enables back", 0, 1);
            prev_bus = VECS[i].e_bus;
        end

        // R1 reserved select ignored
        do_write(2'd3, 3'd5, 1'b1, 8'hF0);
        check(!clocks_stopped, "R1 reserved no stop", clocks_stopped, 0);
        check_ratios("R1 reserved", 4, 7, 0);

        // R5 start value 0 gives 256 cycles
        do_write(2'd0, 3'd2, 1'b1, 8'h00);
        stops = 0;
        wait_run(stops);
        check(stops == 256, "R5 start zero", stops, 256);
        check_ratios("R6 after long wait", 2, 7, 0);

        // R7 writes during wait ignored
        do_write(2'd0, 3'd5, 1'b1, 8'hF8);
        wr_en = 1'b1; wr_sel = 2'd1; wr_data = 8'h01;
        @(negedge clk);
        wr_sel = 2'd0; wr_data = 8'h06; pll_on = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
        stops = 2;
        wait_run(stops);
        check(stops == 8, "R7 wait not restarted", stops, 8);
        check_ratios("R7 writes ignored", 5, 7, 0);

        // R8 reset during wait
        do_write(2'd0, 3'd3, 1'b1, 8'h00);
        repeat (4) @(negedge clk);
        check(clocks_stopped, "R8 in wait", clocks_stopped, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check(!clocks_stopped && clk_en_bus && clk_en_cpu && clk_en_per,
              "R8 reset ends wait", clocks_stopped, 0);
        check_ratios("R8 reset values", 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);

        ended = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule